// File: doc/BRIEF.md
# Dual-Loop Power-Down and Fastlock Controller

This block holds the run-time control state of two independent synthesizer loops. Loop 0 is the IF loop and loop 1 is the RF loop. An external serial interface latches control words and presents each one for a single cycle with a per-loop write strobe. The block turns the latched power-down, three-state, fastlock and current-code fields into per-loop datapath controls: charge-pump enable, charge-pump current code, divider load/reset hold and input debias. It also drives two shared outputs: a reference-oscillator enable and a switch that brings in the extra damping resistor for RF fastlock.

Power-down has two paths. A write that sets the power-down bit while the three-state bit is clear starts a graceful shutdown. The charge pump is first parked in three-state, and the loop powers down only after its reference divider reaches terminal count. A write that sets power-down together with three-state takes effect at once. Clearing the power-down bit restores the loop at once. A separate counter-reset mode holds the dividers of one or both loops and parks their charge pumps. All registers stay writable in every power state.

Top module: `pdc_top`

## Requirements
- R1: After reset both loops are powered up with charge pumps enabled, no divider hold, no debias, both current codes 0, the reference oscillator enabled and the fastlock switch off.
- R2: A control write with power-down 1 and three-state 0 disables that loop's charge pump in the cycle after the write. Debias and divider load stay low until that loop's `ref_tc` is sampled high. Both rise in the cycle after that sample.
- R3: During the three-state phase of R2, a terminal count from the other loop does not end the phase.
- R4: A control write with power-down 1 and three-state 1 asserts debias and divider load for that loop in the cycle after the write, with no wait for a terminal count.
- R5: A control write with power-down 0 clears debias and divider load in the cycle after the write, and it aborts a pending three-state phase. A later terminal count then does not power the loop down.
- R6: `ref_osc_en` is low exactly when the latched power-down bits of both loops are 1.
- R7: The counter-reset mode code is written with `mode_wr`. Code 0 means no hold, 1 means IF only, 2 means RF only and 3 means both. Each selected loop has divider load high and its charge pump disabled from the cycle after the write.
- R8: While a loop's latched fastlock bit is 1, its current-code output is the maximum code (all ones). While the bit is 0, the output is the latched code.
- R9: `fl_sw` follows the latched RF fastlock bit only. IF fastlock leaves it low.
- R10: A control write to a powered-down loop updates its latched current code, and the loop stays powered down.
- R11: A write with three-state 1 and power-down 0 disables the charge pump without debias or divider load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 2 | Per-loop control write strobe (bit 0 IF, bit 1 RF) |
| ctl_pd | input | 2 | Power-down field of the written word, per loop |
| ctl_tri | input | 2 | Charge-pump three-state field, per loop |
| ctl_fl | input | 2 | Fastlock (CP gain) field, per loop |
| ctl_cur_if | input | CP_W | IF charge-pump current code |
| ctl_cur_rf | input | CP_W | RF charge-pump current code |
| mode_wr | input | 1 | Counter-reset mode write strobe |
| mode_code | input | 2 | Counter-reset mode: 0 none, 1 IF, 2 RF, 3 both |
| ref_tc | input | 2 | Reference-divider terminal count, per loop |
| cp_en | output | 2 | Charge-pump enable, per loop |
| cp_cur_if | output | CP_W | Effective IF current code |
| cp_cur_rf | output | CP_W | Effective RF current code |
| cnt_load | output | 2 | Hold R and AB dividers in load state, per loop |
| debias | output | 2 | Input stage debiased (powered down), per loop |
| ref_osc_en | output | 1 | Reference oscillator enable |
| fl_sw | output | 1 | Fastlock damping-resistor switch |

## Verification
The bench first watches the graceful power-down path. It pulses the wrong loop's terminal count and checks that the loop is still only three-stated. A design that took either loop's count would power down early. It then aborts a pending shutdown with a power-up write and follows it with a terminal count, which catches a design that forgets to clear the pending phase. It checks that the oscillator gates only when both power-down bits are set, so a design using OR instead of AND fails. It checks that IF fastlock never drives the resistor switch and that writes made while powered down still change the current code.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
   localparam int NUM_LOOPS = 2;
   localparam int IDX_IF    = 0;
   localparam int IDX_RF    = 1;

   // Power state of one loop
   typedef enum logic [1:0] {
      PDC_UP   = 2'd0,
      PDC_TRI  = 2'd1,
      PDC_DOWN = 2'd2
   } pdc_state_e;

   // Counter-reset mode encoding
   localparam logic [1:0] MODE_NONE = 2'd0;
   localparam logic [1:0] MODE_IF   = 2'd1;
   localparam logic [1:0] MODE_RF   = 2'd2;
   localparam logic [1:0] MODE_BOTH = 2'd3;
endpackage

// File: rtl/pdc_mode_dec.sv
module pdc_mode_dec
   import pdc_pkg::*;
#(
   parameter int LOOPS = NUM_LOOPS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [1:0]       mode_code,
   output logic [LOOPS-1:0] hold
);
   logic [1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= MODE_NONE;
      else if (mode_wr)
         mode_q <= mode_code;
   end

   always_comb begin
      hold = '0;
      unique case (mode_q)
         MODE_NONE: hold = '0;
         MODE_IF:   hold[IDX_IF] = 1'b1;
         MODE_RF:   hold[IDX_RF] = 1'b1;
         MODE_BOTH: begin
            hold[IDX_IF] = 1'b1;
            hold[IDX_RF] = 1'b1;
         end
         default:   hold = '0;
      endcase
   end
endmodule

// File: rtl/pdc_cur_sel.sv
module pdc_cur_sel #(
   parameter int              CP_W         = 3,
   parameter bit              FL_FORCE_MAX = 1'b1,
   parameter logic [CP_W-1:0] FL_CODE      = '1
) (
   input  logic [CP_W-1:0] code_q,
   input  logic            fl_q,
   output logic [CP_W-1:0] code_out
);
   localparam logic [CP_W-1:0] MAX_CODE = {CP_W{1'b1}};

   generate
      if (FL_FORCE_MAX) begin : g_max
         assign code_out = fl_q ? MAX_CODE : code_q;
      end else begin : g_fixed
         assign code_out = fl_q ? FL_CODE : code_q;
      end
   endgenerate
endmodule

// File: rtl/pdc_loop_ctl.sv
module pdc_loop_ctl
   import pdc_pkg::*;
#(
   parameter int CP_W         = 3,
   parameter bit FL_FORCE_MAX = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic            pd_in,
   input  logic            tri_in,
   input  logic            fl_in,
   input  logic [CP_W-1:0] cur_in,
   input  logic            hold,
   input  logic            tc,
   output logic            cp_en,
   output logic [CP_W-1:0] cur_out,
   output logic            cnt_load,
   output logic            debias,
   output logic            pd_q,
   output logic            fl_q
);
   pdc_state_e      st_q, st_d;
   logic            tri_q;
   logic [CP_W-1:0] cur_q;

   // Latched control fields; accepted in every power state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q  <= 1'b0;
         tri_q <= 1'b0;
         fl_q  <= 1'b0;
         cur_q <= '0;
      end else if (wr) begin
         pd_q  <= pd_in;
         tri_q <= tri_in;
         fl_q  <= fl_in;
         cur_q <= cur_in;
      end
   end

   // Power sequencing
   always_comb begin
      st_d = st_q;
      if (wr) begin
         if (!pd_in)
            st_d = PDC_UP;
         else if (tri_in || st_q == PDC_DOWN)
            st_d = PDC_DOWN;
         else
            st_d = PDC_TRI;
      end else if (st_q == PDC_TRI && tc) begin
         st_d = PDC_DOWN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= PDC_UP;
      else
         st_q <= st_d;
   end

   assign debias   = (st_q == PDC_DOWN);
   assign cnt_load = debias | hold;
   assign cp_en    = (st_q == PDC_UP) & ~tri_q & ~hold;

   pdc_cur_sel #(
      .CP_W        (CP_W),
      .FL_FORCE_MAX(FL_FORCE_MAX)
   ) u_cur (
      .code_q  (cur_q),
      .fl_q    (fl_q),
      .code_out(cur_out)
   );
endmodule

// File: rtl/pdc_top.sv
module pdc_top
   import pdc_pkg::*;
#(
   parameter int CP_W         = 3,
   parameter bit FL_FORCE_MAX = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      ctl_wr,
   input  logic [1:0]      ctl_pd,
   input  logic [1:0]      ctl_tri,
   input  logic [1:0]      ctl_fl,
   input  logic [CP_W-1:0] ctl_cur_if,
   input  logic [CP_W-1:0] ctl_cur_rf,
   input  logic            mode_wr,
   input  logic [1:0]      mode_code,
   input  logic [1:0]      ref_tc,
   output logic [1:0]      cp_en,
   output logic [CP_W-1:0] cp_cur_if,
   output logic [CP_W-1:0] cp_cur_rf,
   output logic [1:0]      cnt_load,
   output logic [1:0]      debias,
   output logic            ref_osc_en,
   output logic            fl_sw
);
   localparam int LOOPS = NUM_LOOPS;

   generate
      if (CP_W < 1 || CP_W > 8) begin : g_bad_cpw
         $error("pdc_top: CP_W must be within 1..8");
      end
   endgenerate

   logic [LOOPS-1:0] hold;
   logic [LOOPS-1:0] pd_q;
   logic [LOOPS-1:0] fl_q;
   logic [CP_W-1:0]  cur_in  [LOOPS];
   logic [CP_W-1:0]  cur_out [LOOPS];

   assign cur_in[IDX_IF] = ctl_cur_if;
   assign cur_in[IDX_RF] = ctl_cur_rf;

   pdc_mode_dec #(.LOOPS(LOOPS)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_wr  (mode_wr),
      .mode_code(mode_code),
      .hold     (hold)
   );

   generate
      for (genvar i = 0; i < LOOPS; i++) begin : g_loop
         pdc_loop_ctl #(
            .CP_W        (CP_W),
            .FL_FORCE_MAX(FL_FORCE_MAX)
         ) u_loop (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (ctl_wr[i]),
            .pd_in   (ctl_pd[i]),
            .tri_in  (ctl_tri[i]),
            .fl_in   (ctl_fl[i]),
            .cur_in  (cur_in[i]),
            .hold    (hold[i]),
            .tc      (ref_tc[i]),
            .cp_en   (cp_en[i]),
            .cur_out (cur_out[i]),
            .cnt_load(cnt_load[i]),
            .debias  (debias[i]),
            .pd_q    (pd_q[i]),
            .fl_q    (fl_q[i])
         );
      end
   endgenerate

   assign cp_cur_if  = cur_out[IDX_IF];
   assign cp_cur_rf  = cur_out[IDX_RF];
   assign ref_osc_en = ~(&pd_q);
   assign fl_sw      = fl_q[IDX_RF];
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
   parameter int CP_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      ctl_wr,
   input logic [1:0]      ctl_pd,
   input logic [1:0]      ctl_tri,
   input logic [1:0]      mode_wr,
   input logic [1:0]      ref_tc,
   input logic [1:0]      cp_en,
   input logic [CP_W-1:0] cp_cur_rf,
   input logic [1:0]      cnt_load,
   input logic [1:0]      debias,
   input logic            ref_osc_en,
   input logic            fl_sw
);
   generate
      for (genvar i = 0; i < 2; i++) begin : g_chk
         // R4: three-stated power-down write takes effect next cycle
         a_r4_async_down: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr[i] && ctl_pd[i] && ctl_tri[i]) |=> (debias[i] && cnt_load[i]));
         // R5: power-up write clears debias next cycle
         a_r5_power_up: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr[i] && !ctl_pd[i]) |=> !debias[i]);
         // R2 / R3: debias only rises after own terminal count or an async write
         a_r3_own_tc: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(debias[i]) |-> $past(ref_tc[i] || (ctl_wr[i] && ctl_pd[i])));
         // R2: a powered-down loop never drives its charge pump
         a_r2_cp_off_down: assert property (@(posedge clk) disable iff (!rst_n)
            debias[i] |-> !cp_en[i]);
      end
   endgenerate

   // R6: oscillator gated only when both loops are at least three-stated
   a_r6_ref_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_osc_en |-> (cp_en == 2'b00));
   // R8 / R9: fastlock switch implies maximum RF current
   a_r9_fl_max: assert property (@(posedge clk) disable iff (!rst_n)
      fl_sw |-> (cp_cur_rf == {CP_W{1'b1}}));
   // R7: a loop whose dividers are held never has its charge pump enabled
   a_r7_hold_cp: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_load[0] |-> !cp_en[0]) and (cnt_load[1] |-> !cp_en[1]));
endmodule

bind pdc_top pdc_checker #(.CP_W(CP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_wr    (ctl_wr),
   .ctl_pd    (ctl_pd),
   .ctl_tri   (ctl_tri),
   .mode_wr   ({1'b0, mode_wr}),
   .ref_tc    (ref_tc),
   .cp_en     (cp_en),
   .cp_cur_rf (cp_cur_rf),
   .cnt_load  (cnt_load),
   .debias    (debias),
   .ref_osc_en(ref_osc_en),
   .fl_sw     (fl_sw)
);

// File: tb/sim_pdc_top.sv
module sim_pdc_top;
   localparam int CP_W = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      ctl_wr = '0, ctl_pd = '0, ctl_tri = '0, ctl_fl = '0;
   logic [CP_W-1:0] ctl_cur_if = '0, ctl_cur_rf = '0;
   logic            mode_wr = 1'b0;
   logic [1:0]      mode_code = '0;
   logic [1:0]      ref_tc = '0;
   logic [1:0]      cp_en, cnt_load, debias;
   logic [CP_W-1:0] cp_cur_if, cp_cur_rf;
   logic            ref_osc_en, fl_sw;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pdc_top #(.CP_W(CP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_pd(ctl_pd),
      .ctl_tri(ctl_tri), .ctl_fl(ctl_fl), .ctl_cur_if(ctl_cur_if),
      .ctl_cur_rf(ctl_cur_rf), .mode_wr(mode_wr), .mode_code(mode_code),
      .ref_tc(ref_tc), .cp_en(cp_en), .cp_cur_if(cp_cur_if),
      .cp_cur_rf(cp_cur_rf), .cnt_load(cnt_load), .debias(debias),
      .ref_osc_en(ref_osc_en), .fl_sw(fl_sw)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // one control write to loop l, applied on the next rising edge
   task automatic wr(int l, bit pd, bit tr, bit fl, logic [CP_W-1:0] cur);
      ctl_wr[l]  = 1'b1;
      ctl_pd[l]  = pd;
      ctl_tri[l] = tr;
      ctl_fl[l]  = fl;
      if (l == 0) ctl_cur_if = cur; else ctl_cur_rf = cur;
      step();
      ctl_wr = '0;
   endtask

   task automatic tc(int l);
      ref_tc[l] = 1'b1;
      step();
      ref_tc = '0;
   endtask

   task automatic set_mode(logic [1:0] m);
      mode_wr   = 1'b1;
      mode_code = m;
      step();
      mode_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cp_en", 8'(cp_en), 8'h3);
      chk("R1 cnt_load", 8'(cnt_load), 8'h0);
      chk("R1 debias", 8'(debias), 8'h0);
      chk("R1 ref_osc_en", 8'(ref_osc_en), 8'h1);
      chk("R1 fl_sw", 8'(fl_sw), 8'h0);
      chk("R1 cur", 8'({cp_cur_rf, cp_cur_if}), 8'h0);
   endtask

   task automatic t_sync_down();
      wr(0, 1, 0, 0, 3'd2);
      chk("R2 cp off in tri phase", 8'(cp_en[0]), 8'h0);
      chk("R2 no debias before tc", 8'(debias[0]), 8'h0);
      chk("R2 no load before tc", 8'(cnt_load[0]), 8'h0);
      step();
      chk("R2 still waiting", 8'(debias[0]), 8'h0);
      tc(1);
      chk("R3 other loop tc ignored", 8'(debias[0]), 8'h0);
      tc(0);
      chk("R2 debias after tc", 8'(debias[0]), 8'h1);
      chk("R2 load after tc", 8'(cnt_load[0]), 8'h1);
      chk("R6 one loop down keeps osc", 8'(ref_osc_en), 8'h1);
   endtask

   task automatic t_async_down();
      wr(1, 1, 1, 0, 3'd1);
      chk("R4 debias at once", 8'(debias[1]), 8'h1);
      chk("R4 load at once", 8'(cnt_load[1]), 8'h1);
      chk("R6 both down gates osc", 8'(ref_osc_en), 8'h0);
      wr(1, 1, 1, 0, 3'd5);
      chk("R10 code updated while down", 8'(cp_cur_rf), 8'h5);
      chk("R10 still down", 8'(debias[1]), 8'h1);
   endtask

   task automatic t_power_up();
      wr(0, 0, 0, 0, 3'd2);
      chk("R5 debias cleared", 8'(debias[0]), 8'h0);
      chk("R5 load cleared", 8'(cnt_load[0]), 8'h0);
      chk("R5 cp back on", 8'(cp_en[0]), 8'h1);
      chk("R6 osc back on", 8'(ref_osc_en), 8'h1);
      wr(1, 0, 0, 0, 3'd5);
      chk("R5 rf up", 8'(debias[1]), 8'h0);
      // abort a pending tri phase
      wr(0, 1, 0, 0, 3'd2);
      wr(0, 0, 0, 0, 3'd2);
      tc(0);
      chk("R5 abort: no late power-down", 8'(debias[0]), 8'h0);
      chk("R5 abort: cp on", 8'(cp_en[0]), 8'h1);
   endtask

   task automatic t_tristate_only();
      wr(0, 0, 1, 0, 3'd2);
      chk("R11 cp off", 8'(cp_en[0]), 8'h0);
      chk("R11 no debias", 8'(debias[0]), 8'h0);
      chk("R11 no load", 8'(cnt_load[0]), 8'h0);
      wr(0, 0, 0, 0, 3'd2);
   endtask

   task automatic t_counter_reset();
      set_mode(2'd1);
      chk("R7 IF hold load", 8'(cnt_load), 8'h1);
      chk("R7 IF hold cp", 8'(cp_en), 8'h2);
      set_mode(2'd2);
      chk("R7 RF hold load", 8'(cnt_load), 8'h2);
      chk("R7 RF hold cp", 8'(cp_en), 8'h1);
      set_mode(2'd3);
      chk("R7 both load", 8'(cnt_load), 8'h3);
      chk("R7 both cp", 8'(cp_en), 8'h0);
      set_mode(2'd0);
      chk("R7 release", 8'(cnt_load), 8'h0);
      chk("R7 release cp", 8'(cp_en), 8'h3);
   endtask

   task automatic t_fastlock();
      wr(0, 0, 0, 1, 3'd2);
      chk("R8 IF fastlock max", 8'(cp_cur_if), 8'h7);
      chk("R9 IF fastlock no switch", 8'(fl_sw), 8'h0);
      wr(0, 0, 0, 0, 3'd2);
      chk("R8 IF exit fastlock", 8'(cp_cur_if), 8'h2);
      wr(1, 0, 0, 1, 3'd1);
      chk("R8 RF fastlock max", 8'(cp_cur_rf), 8'h7);
      chk("R9 RF switch on", 8'(fl_sw), 8'h1);
      wr(1, 0, 0, 0, 3'd1);
      chk("R9 RF switch off", 8'(fl_sw), 8'h0);
      chk("R8 RF exit fastlock", 8'(cp_cur_rf), 8'h1);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_sync_down();
      t_async_down();
      t_power_up();
      t_tristate_only();
      t_counter_reset();
      t_fastlock();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule